// File: doc/BRIEF.md
# Four-Source Registered Merge Path

This block merges four source words onto one destination word through two storage stages. Each source word goes into its own first-stage storage cell. A select code chooses one of those cells and drives an internal node. A second storage cell sits between that node and the destination output. Every bit position is handled the same way, so the block is a set of parallel channels of `CH_W` bits.

Both stages use the same storage cell. When its latch enable is high, the cell is transparent. When its latch enable is low, it keeps the value it last saw while transparent. When its latch enable is low and its active-low clock enable is asserted, it takes a new value on a rising transition of the transfer clock. The transfer clock is an ordinary input that is sampled on the system clock, and a rising transition is seen when it is high in a cycle after a low one.

The four first-stage cells share the transfer clock and one clock enable, and each has its own latch enable. The second stage has its own latch enable and its own clock enable. This lets new source data be loaded while the destination still holds the previous word. The destination output has an active-low output enable. The driven state is reported as a separate enable output instead of a high-impedance value.

Top module: `mxr_merge_path`

## Requirements
- R1: While `rst_n` is low and every latch enable is low, `a_data` is zero and `a_en` is 0. After reset is released, both storage stages still hold zero.
- R2: A first-stage cell whose latch enable is high passes its source word through in the same cycle. The source word is bits `[s*CH_W +: CH_W]` of `b_data`, and its latch enable is bit `s` of `src_le`.
- R3: After a first-stage latch enable falls, that cell keeps the source word that was present in the last system-clock cycle in which the enable was high.
- R4: With its latch enable low and `src_ce_n` low, a first-stage cell loads its source word at a rising transition of `xfer_clk`. A rising transition is `xfer_clk` high in a cycle after a cycle in which it was low. The new value is visible in the cycle after that transition.
- R5: With `src_ce_n` high, a rising transition of `xfer_clk` leaves every first-stage cell whose latch enable is low unchanged.
- R6: `sel` values 0, 1, 2 and 3 route first-stage cell 0, 1, 2 and 3 onto the internal node. The route is combinational, so while the second stage is transparent a change of `sel` changes `a_data` in the same cycle.
- R7: While `out_le` is high, `a_data` equals the internal node in the same cycle.
- R8: With `out_le` low and `out_ce_n` low, `a_data` takes the internal node value at a rising transition of `xfer_clk`. With `out_le` low and no such transition, `a_data` keeps its value.
- R9: With `out_le` low and `out_ce_n` high, `a_data` keeps its value across rising transitions of `xfer_clk`.
- R10: Out of reset, `a_en` is the inverse of `a_oe_n`. `a_oe_n` has no effect on `a_data` or on either stage.
- R11: Keeping `xfer_clk` high for several cycles causes only one load, in the first of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_data | input | N_SRC*CH_W | Source words; word s is bits [s*CH_W +: CH_W] |
| src_le | input | N_SRC | First-stage latch enables, one per source |
| src_ce_n | input | 1 | Shared active-low first-stage clock enable |
| xfer_clk | input | 1 | Transfer clock, sampled on clk |
| sel | input | SEL_W | Source select code |
| out_le | input | 1 | Second-stage latch enable |
| out_ce_n | input | 1 | Active-low second-stage clock enable |
| a_oe_n | input | 1 | Active-low destination output enable |
| a_data | output | CH_W | Destination word |
| a_en | output | 1 | High when the destination is driven |

## Verification
Directed sequences cover several cases:
- Every select code, applied with both stages transparent. This separates a swapped or stuck select from a correct one.
- Latch enables that open and close while the source word changes. This shows whether a cell keeps the word from the last open cycle or a later one.
- Transfer-clock pulses under each combination of the two clock enables. This separates loads in the first stage from loads in the second.
- A transfer clock held high across several cycles, with changing data. This exposes a load on the level instead of on the transition.

Seeded random stimulus then mixes all controls together. It checks the output and the enable in every cycle against a cycle-level model built from the requirements.

// File: rtl/mxr_pkg.sv
package mxr_pkg;

  // Control pair for one storage cell.
  typedef struct packed {
    logic le;    // transparent while high
    logic ce_n;  // active-low load enable on a transfer edge
  } mxr_ctl_t;

endpackage

// File: rtl/mxr_edge_det.sv
module mxr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fire
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign fire = lvl & ~lvl_q;

  // A level held high yields one load pulse only.
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/mxr_store_cell.sv
module mxr_store_cell
  import mxr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mxr_ctl_t     ctl,
  input  logic         fire,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;
  logic         load;

  always_comb begin
    load   = ctl.le | (fire & ~ctl.ce_n);
    hold_d = hold_q;
    if (load) begin
      hold_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign q = ctl.le ? d : hold_q;

  // While transparent, the stored word tracks the input.
  assert_cell_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.le |=> hold_q == $past(d));

  // A transfer edge with the clock enable asserted loads the input.
  assert_cell_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && fire && !ctl.ce_n) |=> hold_q == $past(d));

  // Without a load condition the word is kept (also covers R8 and R9).
  assert_cell_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && !(fire && !ctl.ce_n)) |=> $stable(hold_q));

endmodule

// File: rtl/mxr_src_mux.sv
module mxr_src_mux #(
  parameter int W     = 4,
  parameter int N     = 4,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0]   din,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout
);

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) begin
        dout = din[i*W +: W];
      end
    end
  end

endmodule

// File: rtl/mxr_merge_path.sv
module mxr_merge_path
  import mxr_pkg::*;
#(
  parameter  int CH_W  = 4,
  parameter  int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC*CH_W-1:0] b_data,
  input  logic [N_SRC-1:0]      src_le,
  input  logic                  src_ce_n,
  input  logic                  xfer_clk,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  out_le,
  input  logic                  out_ce_n,
  input  logic                  a_oe_n,
  output logic [CH_W-1:0]       a_data,
  output logic                  a_en
);

  logic                  fire;
  logic [N_SRC*CH_W-1:0] src_q;
  logic [CH_W-1:0]       mid;
  mxr_ctl_t              out_ctl;

  mxr_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (xfer_clk),
    .fire  (fire)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    mxr_ctl_t ctl;
    assign ctl.le   = src_le[s];
    assign ctl.ce_n = src_ce_n;

    mxr_store_cell #(.W(CH_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl),
      .fire  (fire),
      .d     (b_data[s*CH_W +: CH_W]),
      .q     (src_q[s*CH_W +: CH_W])
    );
  end

  mxr_src_mux #(.W(CH_W), .N(N_SRC), .SEL_W(SEL_W)) u_mux (
    .din  (src_q),
    .sel  (sel),
    .dout (mid)
  );

  assign out_ctl.le   = out_le;
  assign out_ctl.ce_n = out_ce_n;

  mxr_store_cell #(.W(CH_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (out_ctl),
    .fire  (fire),
    .d     (mid),
    .q     (a_data)
  );

  assign a_en = rst_n & ~a_oe_n;

endmodule

// File: tb/mxr_merge_path_bench.sv
module mxr_merge_path_bench;

  localparam int W  = 4;
  localparam int N  = 4;
  localparam int SW = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N*W-1:0] b_data;
  logic [N-1:0]   src_le;
  logic           src_ce_n;
  logic           xfer_clk;
  logic [SW-1:0]  sel;
  logic           out_le;
  logic           out_ce_n;
  logic           a_oe_n;
  logic [W-1:0]   a_data;
  logic           a_en;

  int checks = 0;
  int fails  = 0;

  // Cycle-level model state.
  logic [W-1:0] m_src [N];
  logic [W-1:0] m_out;
  logic         m_xq;

  always #5 clk = ~clk;

  mxr_merge_path u_mxr_merge_path (
    .clk(clk), .rst_n(rst_n), .b_data(b_data), .src_le(src_le),
    .src_ce_n(src_ce_n), .xfer_clk(xfer_clk), .sel(sel), .out_le(out_le),
    .out_ce_n(out_ce_n), .a_oe_n(a_oe_n), .a_data(a_data), .a_en(a_en)
  );

  function automatic logic [W-1:0] src_view(int s);
    return src_le[s] ? b_data[s*W +: W] : m_src[s];
  endfunction

  function automatic logic [W-1:0] mid_view();
    return src_view(int'(sel));
  endfunction

  function automatic logic [W-1:0] exp_a();
    return out_le ? mid_view() : m_out;
  endfunction

  task automatic step(input string tag);
    logic [W-1:0] nsrc [N];
    logic [W-1:0] nout;
    logic         fire;
    #1;
    checks++;
    if (a_data !== exp_a()) begin
      fails++;
      $display("FAIL %s a_data actual %h expected %h", tag, a_data, exp_a());
    end
    checks++;
    if (a_en !== (rst_n & ~a_oe_n)) begin
      fails++;
      $display("FAIL %s a_en actual %b expected %b", tag, a_en, rst_n & ~a_oe_n);
    end
    fire = xfer_clk & ~m_xq;
    for (int s = 0; s < N; s++) begin
      nsrc[s] = m_src[s];
      if (src_le[s] || (fire && !src_ce_n)) nsrc[s] = b_data[s*W +: W];
    end
    nout = m_out;
    if (out_le || (fire && !out_ce_n)) nout = mid_view();
    @(posedge clk);
    if (!rst_n) begin
      for (int s = 0; s < N; s++) m_src[s] = '0;
      m_out = '0;
      m_xq  = 1'b0;
    end else begin
      for (int s = 0; s < N; s++) m_src[s] = nsrc[s];
      m_out = nout;
      m_xq  = xfer_clk;
    end
    @(negedge clk);
  endtask

  task automatic pulse(input string tag);
    xfer_clk = 1'b1; step(tag);
    xfer_clk = 1'b0; step(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int s = 0; s < N; s++) m_src[s] = '0;
    m_out = '0; m_xq = 1'b0;
    rst_n = 1'b0; b_data = 16'hA5C3; src_le = '0; src_ce_n = 1'b0;
    xfer_clk = 1'b0; sel = '0; out_le = 1'b0; out_ce_n = 1'b0; a_oe_n = 1'b0;
    @(negedge clk);
    step("R1 reset");
    xfer_clk = 1'b1; step("R1 reset");
    xfer_clk = 1'b0; step("R1 reset");
    rst_n = 1'b1; a_oe_n = 1'b1;
    step("R1 after release");
    a_oe_n = 1'b0; step("R10 enable");
    a_oe_n = 1'b1; step("R10 disable");
    a_oe_n = 1'b0;

    // R2 / R7: both stages transparent, source 0
    src_ce_n = 1'b1; out_ce_n = 1'b1;
    src_le = 4'b0001; out_le = 1'b1; sel = 2'd0; b_data = 16'h0007;
    step("R2 transparent");
    b_data = 16'h000C; step("R7 follow");
    // R3: close latch, data changes
    src_le = 4'b0000; step("R3 close");
    b_data = 16'h0003; step("R3 holds");
    // R6: all open, distinct words, sweep select
    src_le = 4'b1111; b_data = 16'h9E51;
    for (int k = 0; k < 4; k++) begin sel = SW'(k); step("R6 select"); end
    src_le = 4'b0000; step("R6 closed");
    // R4: clocked first-stage load
    b_data = 16'h2468; src_ce_n = 1'b0; sel = 2'd2;
    step("R4 before edge");
    pulse("R4 load");
    // R5: disabled clock enable
    src_ce_n = 1'b1; b_data = 16'hBDF1;
    pulse("R5 no load");
    for (int k = 0; k < 4; k++) begin sel = SW'(k); step("R5 kept"); end
    // R11: level held high loads once
    src_ce_n = 1'b0; sel = 2'd1; b_data = 16'h1111; xfer_clk = 1'b1;
    step("R11 first");
    b_data = 16'h7777; step("R11 held");
    b_data = 16'h3333; step("R11 held");
    xfer_clk = 1'b0; step("R11 low");
    // R8 / R9: second stage clocked
    out_le = 1'b0; src_le = 4'b1111; b_data = 16'h5A5A; sel = 2'd0;
    step("R8 hold no edge");
    out_ce_n = 1'b0; pulse("R8 load");
    b_data = 16'hC3C3; step("R8 hold");
    out_ce_n = 1'b1; pulse("R9 no load");
    // R10: output enable does not touch data
    a_oe_n = 1'b1; b_data = 16'h0F0F; step("R10 disabled");
    a_oe_n = 1'b0; step("R10 driven");

    // Seeded random mix
    for (int i = 0; i < 3000; i++) begin
      b_data   = 16'($urandom);
      src_le   = 4'($urandom) & 4'($urandom);
      src_ce_n = 1'($urandom);
      xfer_clk = 1'($urandom);
      sel      = SW'($urandom);
      out_le   = ($urandom % 4) == 0;
      out_ce_n = 1'($urandom);
      a_oe_n   = ($urandom % 5) == 0;
      step("R2-mix R4 R8 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule